// File: doc/BRIEF.md
# Programmable Preload Modulus Divider

This block divides its input clock by a programmable integer N between 1 and 10. It emits one single-cycle terminal pulse per N clock cycles, which makes it suitable as the feedback divider of a phase-locked loop. Inside it is a fixed decade counter whose modulus is set by what it loads when each division period ends, not by a variable compare value.

A direction input selects one of two counting schemes. Counting upward, the counter loads the complement 10 − N and climbs to 9. The cycle that shows 9 raises the terminal pulse, and the next edge reloads the complement. Counting downward, the counter loads N and steps down. The zero state is merged with the reload: the edge that would take the count from 1 to 0 loads N instead, so the reload cycle shows N and carries the pulse.

The controller is a six-state machine. `UP_LOAD` and `DN_LOAD` are the quiet states entered by reset. `UP_STEP` increments and goes to `UP_CARRY` when the next value is 9. `UP_CARRY` always reloads. `DN_STEP` decrements, and at count 1 it reloads into `DN_MERGE`. `DN_MERGE` decrements into `DN_STEP`, or reloads again when N is 1. Every reload samples the modulus and direction inputs again and enters `UP_STEP`, `UP_CARRY` or `DN_MERGE` to match.

Top module: `preload_div`

## Requirements
- R1: With modulus and direction held constant, the terminal pulse repeats exactly every N clock cycles in both directions.
- R2: With `dir_down_i` = 0 (up), the count runs from 10 − N up to 9 in steps of one. `term_o` is high exactly on cycles that show 9, and the edge leaving 9 loads 10 − N.
- R3: With `dir_down_i` = 1 (down), the count shows N and falls by one per cycle to 1. The edge leaving 1 loads N again. `term_o` is high on the cycle that shows the reloaded N, and the value 0 is never shown.
- R4: With N = 1, `term_o` is high on every cycle after the reset cycle, and the count stays at 9 (up) or 1 (down).
- R5: Changes to `modulus_i` or `dir_down_i` are sampled only at a reload edge, so between reloads the count keeps stepping by one in the direction latched at the last reload.
- R6: A `modulus_i` value of 0 or greater than 10 acts as N = 10.
- R7: A cycle with `srst_i` high loads the count with 10 − N (up) or N (down), using the inputs present at that edge, and forces `term_o` low on the following cycle.
- R8: The count never exceeds 9, except that it shows 10 in down mode when N is 10.
- R9: For N ≥ 2 with direction and modulus held, `term_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock being divided |
| srst_i | input | 1 | Synchronous reset, active high |
| modulus_i | input | CNT_W (4) | Division ratio N, unsigned binary |
| dir_down_i | input | 1 | Counting direction: 0 up with complement preload, 1 down with merged zero |
| count_o | output | CNT_W (4) | Current counter value |
| term_o | output | 1 | Terminal pulse, one per division period |

## Verification
The bench uses the default parameters, a 4-bit modulus field and a decade limit of 10. With these values every encodable modulus code can be reached, including 0 and 11 to 15, so the clamp is exercised both in a directed sweep and by random modulus changes. Each ratio from 1 to 10 is run in both directions long enough to measure the pulse spacing. The decade limit also makes the down-mode display of 10 reachable. Random changes of direction and modulus in the middle of a period exercise the rule that inputs are taken only at a reload.

// File: rtl/preload_div_pkg.sv
`timescale 1ns/1ps
package preload_div_pkg;

    // Controller states. The two LOAD states are quiet entry points after
    // reset; CARRY and MERGE are the only states that drive the pulse.
    typedef enum logic [2:0] {
        ST_UP_LOAD  = 3'd0,
        ST_UP_STEP  = 3'd1,
        ST_UP_CARRY = 3'd2,
        ST_DN_LOAD  = 3'd3,
        ST_DN_STEP  = 3'd4,
        ST_DN_MERGE = 3'd5
    } pd_state_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } pd_dir_e;

endpackage

// File: rtl/pd_modulus_clamp.sv
`timescale 1ns/1ps
module pd_modulus_clamp #(
    parameter int CNT_W     = 4,
    parameter int MOD_LIMIT = 10
) (
    input  logic             clk_i,
    input  logic             srst_i,
    input  logic [CNT_W-1:0] modulus_i,
    output logic [CNT_W-1:0] n_eff_o,
    output logic [CNT_W-1:0] up_pre_o,
    output logic [CNT_W-1:0] dn_pre_o
);

    localparam int              CODE_MAX = (1 << CNT_W) - 1;
    localparam logic [CNT_W-1:0] LIM_V   = CNT_W'(MOD_LIMIT);

    logic over_range;

    // Only build the upper compare when the field can encode values above
    // the decade limit.
    generate
        if (CODE_MAX > MOD_LIMIT) begin : g_upper_check
            assign over_range = (modulus_i > LIM_V);
        end else begin : g_no_upper_check
            assign over_range = 1'b0;
        end
    endgenerate

    always_comb begin
        if ((modulus_i == '0) || over_range) begin
            n_eff_o = LIM_V;
        end else begin
            n_eff_o = modulus_i;
        end
    end

    // Complement preload for up counting, ratio itself for down counting.
    assign up_pre_o = LIM_V - n_eff_o;
    assign dn_pre_o = n_eff_o;

    AST_CLAMP_RANGE: assert property (@(posedge clk_i) disable iff (srst_i)
        (n_eff_o != '0) && (n_eff_o <= LIM_V)); // R6

endmodule

// File: rtl/pd_step_unit.sv
`timescale 1ns/1ps
module pd_step_unit #(
    parameter int CNT_W     = 4,
    parameter int MOD_LIMIT = 10
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] plus1_o,
    output logic [CNT_W-1:0] minus1_o,
    output logic             at_top_o,
    output logic             at_floor_o,
    output logic             next_top_o
);

    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP_V = CNT_W'(MOD_LIMIT - 1);

    assign plus1_o    = cnt_i + ONE_V;
    assign minus1_o   = cnt_i - ONE_V;
    assign at_top_o   = (cnt_i == TOP_V);
    assign at_floor_o = (cnt_i <= ONE_V);
    assign next_top_o = (plus1_o == TOP_V);

endmodule

// File: rtl/pd_count_fsm.sv
`timescale 1ns/1ps
module pd_count_fsm
    import preload_div_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int MOD_LIMIT = 10
) (
    input  logic             clk_i,
    input  logic             srst_i,
    input  logic             dir_down_i,
    input  logic [CNT_W-1:0] up_pre_i,
    input  logic [CNT_W-1:0] dn_pre_i,
    input  logic [CNT_W-1:0] plus1_i,
    input  logic [CNT_W-1:0] minus1_i,
    input  logic             at_top_i,
    input  logic             at_floor_i,
    input  logic             next_top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             term_o
);

    localparam logic [CNT_W-1:0] TOP_V = CNT_W'(MOD_LIMIT - 1);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(MOD_LIMIT);
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    pd_state_e        state_q, state_d;
    pd_state_e        rl_state;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] rl_cnt;
    logic             up_side, dn_side;

    // Reload target: the inputs are sampled fresh at every reload edge.
    always_comb begin
        if (pd_dir_e'(dir_down_i) == DIR_DOWN) begin
            rl_cnt   = dn_pre_i;
            rl_state = ST_DN_MERGE;
        end else begin
            rl_cnt   = up_pre_i;
            rl_state = (up_pre_i == TOP_V) ? ST_UP_CARRY : ST_UP_STEP;
        end
    end

    // Next-state and next-count decision.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_UP_LOAD, ST_UP_STEP: begin
                if (at_top_i) begin
                    state_d = rl_state;
                    cnt_d   = rl_cnt;
                end else begin
                    cnt_d   = plus1_i;
                    state_d = next_top_i ? ST_UP_CARRY : ST_UP_STEP;
                end
            end
            ST_UP_CARRY: begin
                state_d = rl_state;
                cnt_d   = rl_cnt;
            end
            ST_DN_LOAD, ST_DN_STEP, ST_DN_MERGE: begin
                if (at_floor_i) begin
                    state_d = rl_state;
                    cnt_d   = rl_cnt;
                end else begin
                    cnt_d   = minus1_i;
                    state_d = ST_DN_STEP;
                end
            end
            default: begin
                state_d = rl_state;
                cnt_d   = rl_cnt;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            if (pd_dir_e'(dir_down_i) == DIR_DOWN) begin
                state_q <= ST_DN_LOAD;
                cnt_q   <= dn_pre_i;
            end else begin
                state_q <= ST_UP_LOAD;
                cnt_q   <= up_pre_i;
            end
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output decode: the pulse comes straight from the state flops.
    always_comb begin
        term_o  = 1'b0;
        up_side = 1'b0;
        dn_side = 1'b0;
        unique case (state_q)
            ST_UP_LOAD, ST_UP_STEP: up_side = 1'b1;
            ST_UP_CARRY: begin
                up_side = 1'b1;
                term_o  = 1'b1;
            end
            ST_DN_LOAD, ST_DN_STEP: dn_side = 1'b1;
            ST_DN_MERGE: begin
                dn_side = 1'b1;
                term_o  = 1'b1;
            end
            default: term_o = 1'b0;
        endcase
    end

    assign cnt_o = cnt_q;

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        srst_i |=> !term_o); // R7

    AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (srst_i)
        cnt_q <= LIM_V); // R8

    AST_TEN_ONLY_DOWN: assert property (@(posedge clk_i) disable iff (srst_i)
        (cnt_q == LIM_V) |-> dn_side); // R8

    AST_UP_ADVANCE: assert property (@(posedge clk_i) disable iff (srst_i)
        ((state_q == ST_UP_LOAD || state_q == ST_UP_STEP) && cnt_q != TOP_V)
        |=> (cnt_q == $past(cnt_q) + ONE_V)); // R5

    AST_DN_ADVANCE: assert property (@(posedge clk_i) disable iff (srst_i)
        (dn_side && cnt_q > ONE_V) |=> (cnt_q == $past(cnt_q) - ONE_V)); // R5

    AST_NO_ZERO_DOWN: assert property (@(posedge clk_i) disable iff (srst_i)
        dn_side |-> (cnt_q != '0)); // R3

    AST_CARRY_AT_TOP: assert property (@(posedge clk_i) disable iff (srst_i)
        (term_o && up_side) |-> (cnt_q == TOP_V)); // R2

    AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (srst_i)
        (state_q == ST_DN_MERGE && cnt_q > ONE_V) |=> !term_o); // R9

endmodule

// File: rtl/preload_div.sv
`timescale 1ns/1ps
module preload_div #(
    parameter int CNT_W     = 4,
    parameter int MOD_LIMIT = 10
) (
    input  logic             clk_i,
    input  logic             srst_i,
    input  logic [CNT_W-1:0] modulus_i,
    input  logic             dir_down_i,
    output logic [CNT_W-1:0] count_o,
    output logic             term_o
);

    logic [CNT_W-1:0] n_eff;
    logic [CNT_W-1:0] up_pre;
    logic [CNT_W-1:0] dn_pre;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] plus1;
    logic [CNT_W-1:0] minus1;
    logic             at_top;
    logic             at_floor;
    logic             next_top;

    pd_modulus_clamp #(
        .CNT_W     (CNT_W),
        .MOD_LIMIT (MOD_LIMIT)
    ) u_clamp (
        .clk_i     (clk_i),
        .srst_i    (srst_i),
        .modulus_i (modulus_i),
        .n_eff_o   (n_eff),
        .up_pre_o  (up_pre),
        .dn_pre_o  (dn_pre)
    );

    pd_step_unit #(
        .CNT_W     (CNT_W),
        .MOD_LIMIT (MOD_LIMIT)
    ) u_step (
        .cnt_i      (cnt),
        .plus1_o    (plus1),
        .minus1_o   (minus1),
        .at_top_o   (at_top),
        .at_floor_o (at_floor),
        .next_top_o (next_top)
    );

    pd_count_fsm #(
        .CNT_W     (CNT_W),
        .MOD_LIMIT (MOD_LIMIT)
    ) u_fsm (
        .clk_i      (clk_i),
        .srst_i     (srst_i),
        .dir_down_i (dir_down_i),
        .up_pre_i   (up_pre),
        .dn_pre_i   (dn_pre),
        .plus1_i    (plus1),
        .minus1_i   (minus1),
        .at_top_i   (at_top),
        .at_floor_i (at_floor),
        .next_top_i (next_top),
        .cnt_o      (cnt),
        .term_o     (term_o)
    );

    assign count_o = cnt;

    AST_DOWN_RELOAD_VALUE: assert property (@(posedge clk_i) disable iff (srst_i)
        (term_o && dir_down_i && count_o != '0 && $past(count_o) == CNT_W'(1) && !$past(srst_i))
        |-> (count_o == $past(n_eff))); // R3

endmodule

// File: tb/preload_div_bench.sv
`timescale 1ns/1ps
module preload_div_bench;

    localparam int CNT_W     = 4;
    localparam int MOD_LIMIT = 10;

    logic             clk = 1'b0;
    logic             srst;
    logic [CNT_W-1:0] modn;
    logic             dird;
    logic [CNT_W-1:0] cnt;
    logic             term;

    int checks = 0;
    int fails  = 0;

    int m_cnt  = 0;
    bit m_term = 1'b0;
    bit m_down = 1'b0;

    always #4 clk = ~clk;

    preload_div #(
        .CNT_W     (CNT_W),
        .MOD_LIMIT (MOD_LIMIT)
    ) u_preload_div (
        .clk_i      (clk),
        .srst_i     (srst),
        .modulus_i  (modn),
        .dir_down_i (dird),
        .count_o    (cnt),
        .term_o     (term)
    );

    function automatic int clampn(int n);
        return (n == 0 || n > MOD_LIMIT) ? MOD_LIMIT : n;
    endfunction

    function automatic int up_preload(int n);
        return MOD_LIMIT - clampn(n);
    endfunction

    // Expected behaviour taken from the requirements.
    task automatic model_step(bit r, int n, bit d);
        bit reload;
        if (r) begin
            m_down = d;
            m_cnt  = d ? clampn(n) : up_preload(n);
            m_term = 1'b0;
        end else begin
            reload = m_down ? (m_cnt <= 1) : (m_cnt == MOD_LIMIT - 1);
            if (reload) begin
                m_down = d;
                if (d) begin
                    m_cnt  = clampn(n);
                    m_term = 1'b1;
                end else begin
                    m_cnt  = up_preload(n);
                    m_term = (m_cnt == MOD_LIMIT - 1);
                end
            end else if (m_down) begin
                m_cnt  = m_cnt - 1;
                m_term = 1'b0;
            end else begin
                m_cnt  = m_cnt + 1;
                m_term = (m_cnt == MOD_LIMIT - 1);
            end
        end
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(string req);
        bit r;
        int n;
        bit d;
        r = srst;
        n = int'(modn);
        d = dird;
        @(posedge clk);
        #1;
        model_step(r, n, d);
        checks++;
        if (int'(cnt) != m_cnt || term != m_term) begin
            fails++;
            $display("FAIL %s count/term: actual=%0d/%0d expected=%0d/%0d",
                     req, cnt, term, m_cnt, m_term);
        end
    endtask

    task automatic do_reset(int n, bit d);
        srst = 1'b1;
        modn = CNT_W'(n);
        dird = d;
        tick("R7");
        check(term == 1'b0, "R7", "term after reset", int'(term), 0);
        srst = 1'b0;
    endtask

    // Hold N and direction, measure pulse spacing and pulse width.
    task automatic run_period(int n, bit d, string ptag);
        int last_hit = -1;
        int gap      = -1;
        bit prev     = 1'b0;
        bit dbl      = 1'b0;
        bit range_ok = 1'b1;
        bit all_high = 1'b1;
        do_reset(n, d);
        for (int i = 0; i < 3 * MOD_LIMIT + 4; i++) begin
            tick(d ? "R3" : "R2");
            if (term) begin
                if (last_hit >= 0) gap = i - last_hit;
                last_hit = i;
                if (prev) dbl = 1'b1;
            end else begin
                all_high = 1'b0;
            end
            prev = term;
            if (!(int'(cnt) <= MOD_LIMIT - 1 ||
                  (d && clampn(n) == MOD_LIMIT && int'(cnt) == MOD_LIMIT)))
                range_ok = 1'b0;
        end
        check(gap == clampn(n), ptag, "pulse spacing", gap, clampn(n));
        check(range_ok, "R8", "count range", int'(range_ok), 1);
        if (clampn(n) == 1)
            check(all_high, "R4", "term high every cycle", int'(all_high), 1);
        else
            check(!dbl, "R9", "no back-to-back pulse", int'(dbl), 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        srst = 1'b1;
        modn = CNT_W'(6);
        dird = 1'b0;
        void'($urandom(32'd7741));

        // R7: reset state in up mode with N = 6 loads 4.
        tick("R7");
        check(int'(cnt) == 4, "R7", "up preload after reset", int'(cnt), 4);
        check(term == 1'b0, "R7", "term after reset", int'(term), 0);

        // R1 sweep: every ratio in both directions.
        for (int n = 1; n <= MOD_LIMIT; n++) begin
            run_period(n, 1'b0, "R1");
            run_period(n, 1'b1, "R1");
        end

        // R6: out-of-range codes behave as N = 10.
        run_period(0, 1'b0, "R6");
        run_period(0, 1'b1, "R6");
        run_period(13, 1'b0, "R6");
        run_period(15, 1'b1, "R6");

        // R8: down mode with N = 10 shows 10 right after reset.
        do_reset(0, 1'b1);
        check(int'(cnt) == 10, "R8", "down mode shows ten", int'(cnt), 10);
        check(term == 1'b0, "R7", "no pulse in reset cycle", int'(term), 0);

        // R5: change inputs mid-period; up period with N = 6 must finish.
        do_reset(6, 1'b0);
        tick("R2");
        tick("R2");
        check(int'(cnt) == 6, "R5", "count before change", int'(cnt), 6);
        modn = CNT_W'(3);
        dird = 1'b1;
        tick("R5");
        tick("R5");
        tick("R5");
        check(int'(cnt) == 9 && term, "R5", "old period completes at 9", int'(cnt), 9);
        tick("R5");
        check(int'(cnt) == 3 && term, "R3", "reload merges to new N", int'(cnt), 3);
        tick("R3");
        check(int'(cnt) == 2 && !term, "R3", "down step after merge", int'(cnt), 2);
        tick("R3");
        tick("R3");
        check(int'(cnt) == 3 && term, "R3", "second merge cycle", int'(cnt), 3);

        // R5: random changes of modulus, direction and occasional reset.
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 19) == 0) modn = CNT_W'($urandom_range(0, 15));
            if ($urandom_range(0, 29) == 0) dird = ~dird;
            srst = ($urandom_range(0, 199) == 0);
            tick("R5");
        end
        srst = 1'b0;

        finish_run();
    end

endmodule